// File: doc/BRIEF.md
# Subscriber Line State Controller

This block drives the four logic-level mode pins of an analog subscriber line interface from host commands and from an active-low line-status input. It sequences the line through power-off, high-impedance idle feeding, active feeding with normal or reverse polarity, a timed metering-injection window, and ringing. During ringing it makes the ring waveform by flipping the polarity pin at a programmable half-period. It runs a burst/pause cadence and holds active normal polarity during each pause.

The status input is synchronised and debounced before use. Its low level means off-hook in idle or active, and ring trip while ringing. Ring trip stops polarity toggling at once and leaves the line in active normal polarity. All other exits from ringing wait for the next half-period boundary, so no ring half-cycle is cut short. No pin leaves the low level until the supply-good input is high. Every timed interval is counted in a prescaled tick.

Commands arrive on a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while the supply is not good and while a deferred command is waiting for a ring boundary. The host must hold `cmd_valid` and `cmd_op` steady until the command is taken.

Top module: `line_state_ctrl`

## Requirements
- R1: After reset, and in any cycle after `supply_ok` was sampled low, all four mode pins and `cmd_ready` are low. Once `supply_ok` is sampled high the block enters the power-off state with `cmd_ready` high.
- R2: The pin vector {line_pwr_o, sel_a_o, sel_b_o, pol_o} is encoded per state as follows. Power-off is 0000. Idle high-impedance feeding is 1000. Active is 101p, with p=0 for normal and p=1 for reverse polarity. Metering is 111p and keeps the active polarity. Ringing is 110t, where t is the toggling polarity. A ring pause is 1010.
- R3: The `cmd_op` codes are: 0 power-off, 1 idle, 2 active normal, 3 active reverse, 4 metering, 5 ring. An accepted code 0 gives pins 0000 in the next cycle from any state. In power-off only codes 1 to 3 have an effect.
- R4: The status input passes through two synchroniser flops. Its debounced level changes only after the synchronised value has differed from it on `db_len`+1 consecutive edges. A shorter pulse has no effect on the pins.
- R5: In idle, a debounced low status moves the line to active normal (pins 1010). The pins change on the 6th clock edge after the input falls when `db_len`=2.
- R6: In active, a debounced high status that lasts `hook_ticks` ticks returns the line to idle.
- R7: Code 4, in active only, gives pins 111p and raises `meter_win` for `meter_ticks` ticks. The line then returns to active with the same polarity. In idle the code has no effect.
- R8: While ringing, `pol_o` flips every `half_ticks` ticks. Ringing starts with `pol_o`=0.
- R9: A burst lasts at least `burst_ticks` ticks and is followed by a pause of `pause_ticks` ticks in active normal. Ringing then starts again.
- R10: Leaving ringing for a pause, or through a command of code 1 to 3, happens only at a half-period boundary. A command taken mid-half-period is held, with `cmd_ready` low, until that boundary.
- R11: A debounced low status while ringing moves the line to active normal in the very next cycle, without waiting for a boundary.
- R12: One tick occurs every `tick_div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its minimum |
| line_det_n | input | 1 | Asynchronous line status, low = off-hook or ring trip |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Command code (see R3) |
| tick_div | input | DIV_W | Prescaler terminal count |
| db_len | input | DEB_W | Debounce length in cycles |
| half_ticks | input | TMR_W | Ring half-period in ticks |
| burst_ticks | input | TMR_W | Ring burst length in ticks |
| pause_ticks | input | TMR_W | Ring pause length in ticks |
| hook_ticks | input | TMR_W | On-hook timeout in ticks |
| meter_ticks | input | TMR_W | Metering window in ticks |
| line_pwr_o | output | 1 | Line power enable pin |
| sel_a_o | output | 1 | Mode select A pin |
| sel_b_o | output | 1 | Mode select B pin |
| pol_o | output | 1 | Polarity / ring toggle pin |
| meter_win | output | 1 | Metering clock enable window |

## Verification
A taken command shows on the pins at the negedge that follows the accepting edge. A status change reaches the pins on edge `db_len`+4 after the input moves. The bench checks the pins one edge before that point and exactly at it. Ring toggles, pause entry and deferred command exits are measured edge to edge, and must be exactly `half_ticks`×(`tick_div`+1) cycles apart. The first toggle, the metering window, the pause and the on-hook timeout start from a free-running tick phase. For these the bench checks the one-tick-wide range that the requirements allow.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_OFF   = 3'd1,
    ST_IDLE  = 3'd2,
    ST_ACT   = 3'd3,
    ST_METER = 3'd4,
    ST_RING  = 3'd5,
    ST_PAUSE = 3'd6
  } line_st_e;

  localparam logic [2:0] OP_OFF      = 3'd0;
  localparam logic [2:0] OP_IDLE     = 3'd1;
  localparam logic [2:0] OP_ACT_NORM = 3'd2;
  localparam logic [2:0] OP_ACT_REV  = 3'd3;
  localparam logic [2:0] OP_METER    = 3'd4;
  localparam logic [2:0] OP_RING     = 3'd5;

  typedef struct packed {
    logic pwr;
    logic sel_a;
    logic sel_b;
    logic pol;
  } mode_pins_t;
endpackage

// File: rtl/lsc_tick.sv
module lsc_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div != '0) && $stable(div)) |=> !tick); // R12
endmodule

// File: rtl/lsc_debounce.sv
module lsc_debounce #(
  parameter int SYNC = 2,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_n,
  input  logic [CW-1:0] limit,
  output logic          level_n
);
  logic [SYNC-1:0] stg_q;
  logic [CW-1:0]   cnt_q;
  logic            lvl_q;
  logic            raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= {stg_q[SYNC-2:0], async_n};
  end

  assign raw = stg_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (raw == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == limit) begin
      cnt_q <= '0;
      lvl_q <= raw;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign level_n = lvl_q;

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == lvl_q) |=> $stable(lvl_q)); // R4
endmodule

// File: rtl/lsc_interval.sv
module lsc_interval #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign done    = run && tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (run && tick)  cnt_q <= done ? '0 : cnt_inc[W-1:0];
  end
endmodule

// File: rtl/line_state_ctrl.sv
module line_state_ctrl
  import lsc_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DEB_W = 8,
  parameter int TMR_W = 12,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             line_det_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [DIV_W-1:0] tick_div,
  input  logic [DEB_W-1:0] db_len,
  input  logic [TMR_W-1:0] half_ticks,
  input  logic [TMR_W-1:0] burst_ticks,
  input  logic [TMR_W-1:0] pause_ticks,
  input  logic [TMR_W-1:0] hook_ticks,
  input  logic [TMR_W-1:0] meter_ticks,
  output logic             line_pwr_o,
  output logic             sel_a_o,
  output logic             sel_b_o,
  output logic             pol_o,
  output logic             meter_win
);
  localparam int NTMR  = 3;
  localparam int T_HALF  = 0;
  localparam int T_BURST = 1;
  localparam int T_PHASE = 2;

  line_st_e   st_q, st_d;
  logic       pol_q, pol_d;
  logic       pend_q, pend_d;
  logic [2:0] pop_q, pop_d;
  logic       bov_q, bov_d;

  logic tick, db_n;
  logic [NTMR-1:0] t_run, t_clr, t_done;
  logic [TMR_W-1:0] t_lim [NTMR];
  mode_pins_t pins;

  // Prescaler and status conditioning
  lsc_tick #(.W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(tick_div), .tick(tick)
  );

  lsc_debounce #(.SYNC(SYNC), .CW(DEB_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .async_n(line_det_n), .limit(db_len), .level_n(db_n)
  );

  // Interval timers: ring half-period, burst, and a shared phase timer
  logic state_change;
  assign state_change = (st_d != st_q);

  assign t_lim[T_HALF]  = half_ticks;
  assign t_lim[T_BURST] = burst_ticks;
  assign t_lim[T_PHASE] = (st_q == ST_METER) ? meter_ticks :
                          (st_q == ST_PAUSE) ? pause_ticks : hook_ticks;

  assign t_run[T_HALF]  = (st_q == ST_RING);
  assign t_run[T_BURST] = (st_q == ST_RING) && !bov_q;
  assign t_run[T_PHASE] = (st_q == ST_METER) || (st_q == ST_PAUSE) ||
                          ((st_q == ST_ACT) && db_n);

  assign t_clr[T_HALF]  = state_change;
  assign t_clr[T_BURST] = state_change;
  assign t_clr[T_PHASE] = state_change || ((st_q == ST_ACT) && !db_n);

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    lsc_interval #(.W(TMR_W)) u_ivl (
      .clk(clk), .rst_n(rst_n), .clear(t_clr[i]), .run(t_run[i]),
      .tick(tick), .limit(t_lim[i]), .done(t_done[i])
    );
  end

  logic half_done, burst_done, phase_done;
  assign half_done  = t_done[T_HALF];
  assign burst_done = t_done[T_BURST];
  assign phase_done = t_done[T_PHASE];

  // Command decode
  logic fire, off_fire, basic_cmd, pend_basic;
  line_st_e basic_st, pend_st;
  logic basic_pol, pend_pol;

  assign cmd_ready  = (st_q != ST_HOLD) && !pend_q;
  assign fire       = cmd_valid && cmd_ready;
  assign off_fire   = fire && (cmd_op == OP_OFF);
  assign basic_cmd  = fire && ((cmd_op == OP_IDLE) || (cmd_op == OP_ACT_NORM) ||
                               (cmd_op == OP_ACT_REV));
  assign basic_st   = (cmd_op == OP_IDLE) ? ST_IDLE : ST_ACT;
  assign basic_pol  = (cmd_op == OP_ACT_REV);
  assign pend_basic = pend_q;
  assign pend_st    = (pop_q == OP_IDLE) ? ST_IDLE : ST_ACT;
  assign pend_pol   = (pop_q == OP_ACT_REV);

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    pol_d  = pol_q;
    pend_d = pend_q;
    pop_d  = pop_q;
    bov_d  = bov_q || burst_done;
    if (!supply_ok) begin
      st_d   = ST_HOLD;
      pol_d  = 1'b0;
      pend_d = 1'b0;
    end else if (off_fire) begin
      st_d   = ST_OFF;
      pol_d  = 1'b0;
      pend_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_HOLD: st_d = ST_OFF;
        ST_OFF: begin
          if (basic_cmd) begin
            st_d  = basic_st;
            pol_d = basic_pol;
          end
        end
        ST_IDLE: begin
          if (basic_cmd) begin
            st_d  = basic_st;
            pol_d = basic_pol;
          end else if (fire && (cmd_op == OP_RING)) begin
            st_d  = ST_RING;
            pol_d = 1'b0;
          end else if (!db_n) begin
            st_d  = ST_ACT;
            pol_d = 1'b0;
          end
        end
        ST_ACT: begin
          if (basic_cmd) begin
            st_d  = basic_st;
            pol_d = basic_pol;
          end else if (fire && (cmd_op == OP_METER)) begin
            st_d = ST_METER;
          end else if (fire && (cmd_op == OP_RING)) begin
            st_d  = ST_RING;
            pol_d = 1'b0;
          end else if (phase_done) begin
            st_d  = ST_IDLE;
            pol_d = 1'b0;
          end
        end
        ST_METER: begin
          if (phase_done) st_d = ST_ACT;
        end
        ST_RING: begin
          if (!db_n) begin
            st_d   = ST_ACT;
            pol_d  = 1'b0;
            pend_d = 1'b0;
          end else if (half_done) begin
            if (pend_basic) begin
              st_d   = pend_st;
              pol_d  = pend_pol;
              pend_d = 1'b0;
            end else if (basic_cmd) begin
              st_d  = basic_st;
              pol_d = basic_pol;
            end else if (bov_q || burst_done) begin
              st_d  = ST_PAUSE;
              pol_d = 1'b0;
            end else begin
              pol_d = ~pol_q;
            end
          end else if (basic_cmd) begin
            pend_d = 1'b1;
            pop_d  = cmd_op;
          end
        end
        ST_PAUSE: begin
          if (basic_cmd) begin
            st_d  = basic_st;
            pol_d = basic_pol;
          end else if (fire && (cmd_op == OP_RING)) begin
            st_d  = ST_RING;
            pol_d = 1'b0;
          end else if (!db_n) begin
            st_d  = ST_ACT;
            pol_d = 1'b0;
          end else if (phase_done) begin
            st_d  = ST_RING;
            pol_d = 1'b0;
          end
        end
        default: st_d = ST_HOLD;
      endcase
    end
    if ((st_d == ST_RING) && (st_q != ST_RING)) bov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOLD;
      pol_q  <= 1'b0;
      pend_q <= 1'b0;
      pop_q  <= OP_OFF;
      bov_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pol_q  <= pol_d;
      pend_q <= pend_d;
      pop_q  <= pop_d;
      bov_q  <= bov_d;
    end
  end

  // Pin decode
  always_comb begin
    pins = '0;
    unique case (st_q)
      ST_IDLE:  pins = '{pwr: 1'b1, sel_a: 1'b0, sel_b: 1'b0, pol: 1'b0};
      ST_ACT:   pins = '{pwr: 1'b1, sel_a: 1'b0, sel_b: 1'b1, pol: pol_q};
      ST_METER: pins = '{pwr: 1'b1, sel_a: 1'b1, sel_b: 1'b1, pol: pol_q};
      ST_RING:  pins = '{pwr: 1'b1, sel_a: 1'b1, sel_b: 1'b0, pol: pol_q};
      ST_PAUSE: pins = '{pwr: 1'b1, sel_a: 1'b0, sel_b: 1'b1, pol: 1'b0};
      default:  pins = '0;
    endcase
  end

  assign line_pwr_o = pins.pwr;
  assign sel_a_o    = pins.sel_a;
  assign sel_b_o    = pins.sel_b;
  assign pol_o      = pins.pol;
  assign meter_win  = (st_q == ST_METER);

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!line_pwr_o && !sel_a_o && !sel_b_o && !pol_o && !cmd_ready)); // R1
  AST_OFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (off_fire && supply_ok) |=> (!line_pwr_o && !sel_a_o && !sel_b_o && !pol_o)); // R3
  AST_TRIP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RING) && !db_n && supply_ok && !off_fire)
      |=> (line_pwr_o && !sel_a_o && sel_b_o && !pol_o)); // R11
  AST_RING_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RING) && !half_done && db_n && supply_ok && !off_fire)
      |=> ((st_q == ST_RING) && $stable(pol_o))); // R10
  AST_METER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_METER) && !phase_done && supply_ok && !off_fire) |=> meter_win); // R7
endmodule

// File: tb/line_state_ctrl_test.sv
module line_state_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic line_det_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic line_pwr_o, sel_a_o, sel_b_o, pol_o, meter_win;
  logic [3:0] pv;

  localparam int TDIV = 3, DEB = 2, HALF = 5, BURST = 18, PAUSE = 12, HOOK = 10, METER = 8;
  localparam int P = TDIV + 1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_state_ctrl uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .line_det_n(line_det_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .tick_div(8'(TDIV)), .db_len(8'(DEB)), .half_ticks(12'(HALF)),
    .burst_ticks(12'(BURST)), .pause_ticks(12'(PAUSE)), .hook_ticks(12'(HOOK)),
    .meter_ticks(12'(METER)), .line_pwr_o(line_pwr_o), .sel_a_o(sel_a_o),
    .sel_b_o(sel_b_o), .pol_o(pol_o), .meter_win(meter_win)
  );

  assign pv = {line_pwr_o, sel_a_o, sel_b_o, pol_o};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] op);
    int guard = 0;
    while (!cmd_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    cmd_valid = 1'b1;
    cmd_op = op;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_change(input int start, output int n);
    logic [3:0] ref_v = pv;
    n = start;
    do begin
      @(negedge clk);
      n++;
    end while (pv == ref_v && n < 400);
  endtask

  task automatic t_reset;
    chk("R1 pins in hold", pv, 0);
    chk("R1 ready in hold", cmd_ready, 0);
    edges(3);
    chk("R1 pins still held", pv, 0);
    supply_ok = 1'b1;
    edges(1);
    chk("R1 ready after supply good", cmd_ready, 1);
    chk("R2 power-off pins", pv, 0);
  endtask

  task automatic t_encodings;
    send(3'd4);
    chk("R3 metering ignored in power-off", pv, 4'b0000);
    send(3'd1);
    chk("R2 idle pins", pv, 4'b1000);
    send(3'd4);
    edges(4);
    chk("R7 metering ignored in idle", pv, 4'b1000);
    send(3'd2);
    chk("R2 active normal pins", pv, 4'b1010);
    send(3'd3);
    chk("R2 active reverse pins", pv, 4'b1011);
  endtask

  task automatic t_meter;
    int n = 1;
    send(3'd4);
    chk("R7 metering pins keep polarity", pv, 4'b1111);
    chk("R7 window open", meter_win, 1);
    forever begin
      @(negedge clk);
      if (!meter_win || n > 200) break;
      n++;
    end
    chk_rng("R7 window length", n, (METER - 1) * P + 1, METER * P);
    chk("R7 back to active reverse", pv, 4'b1011);
  endtask

  task automatic t_glitch;
    send(3'd1);
    line_det_n = 1'b0;
    edges(2);
    line_det_n = 1'b1;
    edges(10);
    chk("R4 short low pulse ignored", pv, 4'b1000);
  endtask

  task automatic t_offhook;
    line_det_n = 1'b0;
    edges(DEB + 3);
    chk("R5 idle before debounce ends", pv, 4'b1000);
    edges(1);
    chk("R5 off-hook to active normal", pv, 4'b1010);
  endtask

  task automatic t_hook_timeout;
    line_det_n = 1'b1;
    edges(DEB + 3 + (HOOK - 1) * P);
    chk("R6 still active before timeout", pv, 4'b1010);
    edges(5);
    chk("R6 on-hook timeout to idle", pv, 4'b1000);
  endtask

  task automatic t_cadence;
    int n;
    send(3'd5);
    chk("R2 ring entry pins", pv, 4'b1100);
    wait_change(0, n);
    chk_rng("R8 first toggle", n, (HALF - 1) * P + 1, HALF * P);
    chk("R8 polarity after first toggle", pv, 4'b1101);
    wait_change(0, n);
    chk("R8 R12 half period", n, HALF * P);
    wait_change(0, n);
    chk("R8 half period again", n, HALF * P);
    wait_change(0, n);
    chk("R10 pause entry on boundary", n, HALF * P);
    chk("R9 pause pins", pv, 4'b1010);
    wait_change(0, n);
    chk_rng("R9 pause length", n, (PAUSE - 1) * P + 1, PAUSE * P);
    chk("R9 ringing resumes", pv, 4'b1100);
  endtask

  task automatic t_deferred;
    int n;
    wait_change(0, n);
    cmd_valid = 1'b1;
    cmd_op = 3'd3;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 ready low while deferred", cmd_ready, 0);
    wait_change(1, n);
    chk("R10 deferred exit on boundary", n, HALF * P);
    chk("R10 deferred target pins", pv, 4'b1011);
  endtask

  task automatic t_trip;
    send(3'd5);
    line_det_n = 1'b0;
    edges(DEB + 3);
    chk("R11 ringing until trip debounced", pv, 4'b1100);
    edges(1);
    chk("R11 ring trip to active normal", pv, 4'b1010);
    edges(HALF * P + 2);
    chk("R11 no toggling after trip", pv, 4'b1010);
  endtask

  task automatic t_off_any;
    send(3'd0);
    chk("R3 off from active", pv, 4'b0000);
    line_det_n = 1'b1;
    edges(DEB + 6);
    send(3'd1);
    send(3'd5);
    edges(3);
    send(3'd0);
    chk("R3 off from ringing", pv, 4'b0000);
  endtask

  task automatic t_supply_loss;
    send(3'd2);
    chk("R2 active again", pv, 4'b1010);
    supply_ok = 1'b0;
    edges(1);
    chk("R1 pins low on supply loss", pv, 4'b0000);
    chk("R1 ready low on supply loss", cmd_ready, 0);
    supply_ok = 1'b1;
    edges(1);
    chk("R1 ready after supply return", cmd_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(2);
    t_reset();
    t_encodings();
    t_meter();
    t_glitch();
    t_offhook();
    t_hook_timeout();
    t_cadence();
    t_deferred();
    t_trip();
    t_off_any();
    t_supply_loss();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule